// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the lookup front end of a two-way set-associative cache. Every set keeps a single prediction bit naming the way that the next access to that set is expected to hit. When a request is accepted, the set is read using the request index together with that bit, and the predicted way's data goes to the requester in the following cycle. The tags and valid bits of both ways are compared in parallel with this. A correct guess therefore costs one cycle.

If the predicted way does not hold the requested tag, the response is flagged as cancelled in the same cycle, so the requester drops the early data. When the other way holds the line, its data is read and delivered two cycles later, with no cancel flag. The prediction bit then moves to that way. When neither way holds the line, a miss pulse goes to the refill side carrying the set, the tag and the way chosen for the fill. The prediction bit moves to that way. A fill port writes a line into a chosen way; fetching that line from the next level is left to the surrounding logic.

Top module: `wp_lookup`

## Requirements
- R1: After reset the block has no response and no miss pending, `req_ready` is high, every line of both ways is invalid and every set predicts way 0.
- R2: A fill pulse writes the tag and data into the named way of the named set and marks that line valid, in time for a lookup accepted on the next edge.
- R3: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. If the predicted way is valid and its tag equals the request tag, `rsp_valid` is high one cycle later with that way's data and `rsp_cancel` low.
- R4: In the cycle after acceptance, `rsp_valid` is always high and `rsp_data` carries the predicted way's stored data. `rsp_cancel` is high in that cycle exactly when the predicted way is invalid or holds a different tag.
- R5: On a mispredicted hit, `rsp_valid` is low two cycles after acceptance. Three cycles after acceptance it is high with the matching way's data and `rsp_cancel` low.
- R6: On a mispredicted hit, `req_ready` is low in the first and second cycles after acceptance, and `req_valid` has no effect in those cycles.
- R7: A mispredicted hit sets the set's prediction bit to the way that matched.
- R8: When neither way matches, `miss_valid` pulses one cycle after acceptance, together with a cancelled response. It carries the set, the tag and the victim way. The victim is way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid, otherwise the way that was not predicted. Way 0 is encoded 0 and way 1 is encoded 1.
- R9: A miss sets the set's prediction bit to the victim way.
- R10: A miss does not lower `req_ready`. A request to the same set accepted in the very next cycle is predicted with the already updated bit.
- R11: Requests whose predictions are correct can be accepted on every cycle, each answered one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| req_index | input | log2(SETS) | Set of the lookup |
| req_tag | input | TAG_W | Tag of the lookup |
| rsp_valid | output | 1 | Response data present |
| rsp_cancel | output | 1 | Data in this cycle was a wrong guess and must be dropped |
| rsp_data | output | DATA_W | Response data |
| miss_valid | output | 1 | Neither way holds the requested line |
| miss_index | output | log2(SETS) | Set of the missing line |
| miss_tag | output | TAG_W | Tag of the missing line |
| miss_way | output | 1 | Way reserved for the fill |
| fill_valid | input | 1 | Write a line |
| fill_index | input | log2(SETS) | Set written by the fill |
| fill_way | input | 1 | Way written by the fill |
| fill_tag | input | TAG_W | Tag written by the fill |
| fill_data | input | DATA_W | Data written by the fill |

## Verification
A miss is the case where two functions fall in the same cycle. The miss rewrites a set's prediction bit while a following lookup may be reading that same bit, so the miss path and the prediction read meet in one cycle. The bench provokes this by issuing two requests to one set on consecutive cycles, the first of which misses. It judges the result by whether the second response is cancelled, which happens only if the stale bit was used. The same comparison also catches a cancel that coincides with a miss report, since the model predicts both outputs for that cycle on every clock.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int NUM_WAYS = 2;
  typedef logic way_t;
  typedef enum logic [1:0] {
    FX_IDLE = 2'd0,
    FX_WAIT = 2'd1,
    FX_SEND = 2'd2
  } fix_state_e;
endpackage

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
  parameter int SETS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(SETS)-1:0]   rd_idx,
  output wp_pkg::way_t              rd_way,
  input  logic                      wr_en,
  input  logic [$clog2(SETS)-1:0]   wr_idx,
  input  wp_pkg::way_t              wr_way
);
  logic [SETS-1:0] guess_q;
  logic [SETS-1:0] guess_d;

  always_comb begin
    guess_d = guess_q;
    if (wr_en) begin
      guess_d[wr_idx] = wr_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guess_q <= '0;
    end else if (wr_en) begin
      guess_q <= guess_d;
    end
  end

  // an update landing this edge is forwarded to a lookup in the same cycle
  assign rd_way = (wr_en && (wr_idx == rd_idx)) ? wr_way : guess_q[rd_idx];
endmodule

// File: rtl/wp_line_store.sv
module wp_line_store #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       wr_en,
  input  logic [$clog2(SETS)-1:0]                    wr_idx,
  input  wp_pkg::way_t                               wr_way,
  input  logic [TAG_W-1:0]                           wr_tag,
  input  logic [DATA_W-1:0]                          wr_data,
  input  logic [$clog2(SETS)-1:0]                    rd_idx,
  input  wp_pkg::way_t                               rd_way,
  output logic [wp_pkg::NUM_WAYS-1:0][TAG_W-1:0]     rd_tags,
  output logic [wp_pkg::NUM_WAYS-1:0]                rd_vld,
  output logic [DATA_W-1:0]                          rd_data,
  input  logic [$clog2(SETS)-1:0]                    alt_idx,
  input  wp_pkg::way_t                               alt_way,
  output logic [DATA_W-1:0]                          alt_data
);
  localparam int WAYS = wp_pkg::NUM_WAYS;

  logic [WAYS-1:0][DATA_W-1:0] rd_way_data;
  logic [WAYS-1:0][DATA_W-1:0] alt_way_data;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   vld_d;
    logic              way_we;

    assign way_we = wr_en && (wr_way == wp_pkg::way_t'(g));

    always_comb begin
      vld_d = vld_q;
      if (way_we) begin
        vld_d[wr_idx] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
      end else if (way_we) begin
        vld_q <= vld_d;
      end
    end

    always_ff @(posedge clk) begin
      if (way_we) begin
        tag_q[wr_idx]  <= wr_tag;
        data_q[wr_idx] <= wr_data;
      end
    end

    assign rd_tags[g]      = tag_q[rd_idx];
    assign rd_vld[g]       = vld_q[rd_idx];
    assign rd_way_data[g]  = data_q[rd_idx];
    assign alt_way_data[g] = data_q[alt_idx];
  end

  assign rd_data  = rd_way_data[rd_way];
  assign alt_data = alt_way_data[alt_way];
endmodule

// File: rtl/wp_tag_cmp.sv
module wp_tag_cmp #(
  parameter int TAG_W = 12
) (
  input  logic [wp_pkg::NUM_WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [wp_pkg::NUM_WAYS-1:0]            way_vld,
  input  logic [TAG_W-1:0]                       look_tag,
  output logic [wp_pkg::NUM_WAYS-1:0]            way_hit
);
  for (genvar g = 0; g < wp_pkg::NUM_WAYS; g++) begin : g_cmp
    assign way_hit[g] = way_vld[g] && (way_tags[g] == look_tag);
  end
endmodule

// File: rtl/wp_lookup.sv
module wp_lookup #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [$clog2(SETS)-1:0] req_index,
  input  logic [TAG_W-1:0]        req_tag,
  output logic                    rsp_valid,
  output logic                    rsp_cancel,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    miss_valid,
  output logic [$clog2(SETS)-1:0] miss_index,
  output logic [TAG_W-1:0]        miss_tag,
  output logic                    miss_way,
  input  logic                    fill_valid,
  input  logic [$clog2(SETS)-1:0] fill_index,
  input  logic                    fill_way,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [DATA_W-1:0]       fill_data
);
  import wp_pkg::*;
  localparam int IDX_W = $clog2(SETS);
  localparam int WAYS  = NUM_WAYS;

  // reset: asserted at once, released two edges later
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // ---------------- request stage ----------------
  logic                       accept;
  way_t                       guess_way;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic [WAYS-1:0]            set_vld;
  logic [DATA_W-1:0]          guess_data;
  logic [DATA_W-1:0]          other_data;

  // ---------------- check stage ----------------
  logic                       chk_v_q;
  logic [IDX_W-1:0]           chk_idx_q;
  logic [TAG_W-1:0]           chk_tag_q;
  way_t                       chk_way_q;
  logic [DATA_W-1:0]          chk_data_q;
  logic [WAYS-1:0][TAG_W-1:0] chk_tags_q;
  logic [WAYS-1:0]            chk_vld_q;
  logic [WAYS-1:0]            chk_hit;

  logic guess_ok;
  logic any_hit;
  logic wrong_guess;
  logic no_hit;
  way_t hit_way;
  way_t victim_way;
  logic guess_we;
  way_t guess_new;

  // ---------------- correction ----------------
  fix_state_e        fix_q;
  fix_state_e        fix_d;
  logic [DATA_W-1:0] fix_data_q;

  wp_pred_table #(.SETS(SETS)) u_guess (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .rd_idx (req_index),
    .rd_way (guess_way),
    .wr_en  (guess_we),
    .wr_idx (chk_idx_q),
    .wr_way (guess_new)
  );

  wp_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (fill_valid),
    .wr_idx   (fill_index),
    .wr_way   (way_t'(fill_way)),
    .wr_tag   (fill_tag),
    .wr_data  (fill_data),
    .rd_idx   (req_index),
    .rd_way   (guess_way),
    .rd_tags  (set_tags),
    .rd_vld   (set_vld),
    .rd_data  (guess_data),
    .alt_idx  (chk_idx_q),
    .alt_way  (hit_way),
    .alt_data (other_data)
  );

  wp_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .way_tags (chk_tags_q),
    .way_vld  (chk_vld_q),
    .look_tag (chk_tag_q),
    .way_hit  (chk_hit)
  );

  assign guess_ok    = chk_hit[chk_way_q];
  assign any_hit     = |chk_hit;
  assign wrong_guess = chk_v_q && !guess_ok && any_hit;
  assign no_hit      = chk_v_q && !any_hit;
  assign hit_way     = chk_hit[0] ? 1'b0 : 1'b1;

  always_comb begin
    if (!chk_vld_q[0]) begin
      victim_way = 1'b0;
    end else if (!chk_vld_q[1]) begin
      victim_way = 1'b1;
    end else begin
      victim_way = ~chk_way_q;
    end
  end

  assign guess_we  = wrong_guess || no_hit;
  assign guess_new = no_hit ? victim_way : hit_way;

  assign req_ready = (fix_q != FX_WAIT) && !wrong_guess;
  assign accept    = req_valid && req_ready;

  // correction sequencer: next state
  always_comb begin
    fix_d = fix_q;
    unique case (fix_q)
      FX_IDLE: if (wrong_guess) fix_d = FX_WAIT;
      FX_WAIT: fix_d = FX_SEND;
      FX_SEND: fix_d = FX_IDLE;
      default: fix_d = FX_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chk_v_q <= 1'b0;
      fix_q   <= FX_IDLE;
    end else begin
      chk_v_q <= accept;
      fix_q   <= fix_d;
    end
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      chk_idx_q  <= req_index;
      chk_tag_q  <= req_tag;
      chk_way_q  <= guess_way;
      chk_data_q <= guess_data;
      chk_tags_q <= set_tags;
      chk_vld_q  <= set_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wrong_guess) begin
      fix_data_q <= other_data;
    end
  end

  assign rsp_valid  = chk_v_q || (fix_q == FX_SEND);
  assign rsp_cancel = chk_v_q && !guess_ok;
  assign rsp_data   = (fix_q == FX_SEND) ? fix_data_q : chk_data_q;

  assign miss_valid = no_hit;
  assign miss_index = chk_idx_q;
  assign miss_tag   = chk_tag_q;
  assign miss_way   = victim_way;
endmodule

// File: rtl/wp_lookup_chk.sv
module wp_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_cancel,
  input logic miss_valid
);
  // R4: a cancel always rides on a response beat
  a_r4_cancel_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cancel |-> rsp_valid);

  // R8: a miss report comes with the cancelled early data
  a_r8_miss_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |-> rsp_cancel);

  // R3: an accepted request is answered in the next cycle
  a_r3_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R6: a wrong guess blocks intake in its own cycle
  a_r6_block_now: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cancel && !miss_valid) |-> !req_ready);

  // R6, R5: the cycle after a wrong guess is silent and blocked
  a_r6_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cancel && !miss_valid) |=> (!req_ready && !rsp_valid));

  // R5: corrected data two cycles after the cancel
  a_r5_fix_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_cancel && !miss_valid) |-> ##2 (rsp_valid && !rsp_cancel));
endmodule

bind wp_lookup wp_lookup_chk u_wp_lookup_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_cancel (rsp_cancel),
  .miss_valid (miss_valid)
);

// File: tb/tb_wp_lookup.sv
module tb_wp_lookup;
  localparam int SETS   = 8;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = 10;
  localparam int DATA_W = 32;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [IDX_W-1:0]  req_index;
  logic [TAG_W-1:0]  req_tag;
  logic              rsp_valid;
  logic              rsp_cancel;
  logic [DATA_W-1:0] rsp_data;
  logic              miss_valid;
  logic [IDX_W-1:0]  miss_index;
  logic [TAG_W-1:0]  miss_tag;
  logic              miss_way;
  logic              fill_valid;
  logic [IDX_W-1:0]  fill_index;
  logic              fill_way;
  logic [TAG_W-1:0]  fill_tag;
  logic [DATA_W-1:0] fill_data;

  wp_lookup #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [TAG_W-1:0]  m_tag  [0:1][0:SETS-1];
  logic [DATA_W-1:0] m_data [0:1][0:SETS-1];
  bit                m_vld  [0:1][0:SETS-1];
  bit                m_pred [0:SETS-1];

  // expected outputs per cycle, ring of 8 slots
  bit                e_rv [0:7];
  bit                e_rc [0:7];
  bit                e_dk [0:7];
  logic [DATA_W-1:0] e_rd [0:7];
  int                e_rq [0:7];
  bit                e_mv [0:7];
  int                e_mi [0:7];
  logic [TAG_W-1:0]  e_mt [0:7];
  bit                e_mw [0:7];
  bit                e_nr [0:7];

  int mcyc     = 0;
  bit model_on = 1'b0;
  bit last_vic;

  initial begin
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) m_vld[w][s] = 1'b0;   // R1: all invalid
    for (int s = 0; s < SETS; s++) m_pred[s] = 1'b0;        // R1: predict way 0
    for (int s = 0; s < 8; s++) begin
      e_rv[s] = 0; e_rc[s] = 0; e_dk[s] = 0; e_rd[s] = '0; e_rq[s] = 3;
      e_mv[s] = 0; e_mi[s] = 0; e_mt[s] = '0; e_mw[s] = 0; e_nr[s] = 0;
    end
  end

  always @(posedge clk) begin
    if (model_on) begin
      int  k;
      bit  busy;
      k    = mcyc % 8;
      busy = e_nr[k];
      e_rv[k] = 0; e_rc[k] = 0; e_dk[k] = 0; e_mv[k] = 0; e_nr[k] = 0;
      if (req_valid && !busy) begin
        int i, s1, s3;
        bit pw, h0, h1, ph;
        i  = int'(req_index);
        s1 = (mcyc + 1) % 8;
        s3 = (mcyc + 3) % 8;
        pw = m_pred[i];
        h0 = m_vld[0][i] && (m_tag[0][i] == req_tag);
        h1 = m_vld[1][i] && (m_tag[1][i] == req_tag);
        ph = pw ? h1 : h0;
        // R4: early beat carries the predicted way's data
        e_rv[s1] = 1; e_rc[s1] = !ph; e_dk[s1] = m_vld[pw][i];
        e_rd[s1] = m_data[pw][i]; e_rq[s1] = ph ? 3 : 4;
        if (!ph && (h0 || h1)) begin
          bit hw;
          hw = h0 ? 1'b0 : 1'b1;
          // R5: corrected beat three cycles after acceptance
          e_rv[s3] = 1; e_rc[s3] = 0; e_dk[s3] = 1;
          e_rd[s3] = m_data[hw][i]; e_rq[s3] = 5;
          e_nr[s1] = 1; e_nr[(mcyc + 2) % 8] = 1;             // R6
          m_pred[i] = hw;                                      // R7
        end else if (!ph) begin
          bit vic;
          if (!m_vld[0][i])      vic = 1'b0;
          else if (!m_vld[1][i]) vic = 1'b1;
          else                   vic = !pw;
          e_mv[s1] = 1; e_mi[s1] = i; e_mt[s1] = req_tag; e_mw[s1] = vic; // R8
          m_pred[i] = vic;                                     // R9
          last_vic  = vic;
        end
      end
      if (fill_valid) begin
        m_tag[fill_way][fill_index]  = fill_tag;
        m_data[fill_way][fill_index] = fill_data;
        m_vld[fill_way][fill_index]  = 1'b1;
      end
      mcyc++;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_on) begin
      int s;
      s = mcyc % 8;
      check(req_ready === !e_nr[s], 6, "req_ready", 64'(req_ready), 64'(!e_nr[s]));
      check(rsp_valid === e_rv[s], e_rq[s], "rsp_valid", 64'(rsp_valid), 64'(e_rv[s]));
      if (e_rv[s]) begin
        check(rsp_cancel === e_rc[s], e_rq[s], "rsp_cancel", 64'(rsp_cancel), 64'(e_rc[s]));
        if (e_dk[s])
          check(rsp_data === e_rd[s], e_rq[s], "rsp_data", 64'(rsp_data), 64'(e_rd[s]));
      end
      check(miss_valid === e_mv[s], 8, "miss_valid", 64'(miss_valid), 64'(e_mv[s]));
      if (e_mv[s]) begin
        check(int'(miss_index) == e_mi[s], 8, "miss_index", 64'(miss_index), 64'(e_mi[s]));
        check(miss_tag === e_mt[s], 8, "miss_tag", 64'(miss_tag), 64'(e_mt[s]));
        check(miss_way === e_mw[s], 8, "miss_way", 64'(miss_way), 64'(e_mw[s]));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fill(input int idx, input bit way, input int tag, input logic [DATA_W-1:0] d);
    fill_valid = 1'b1; fill_index = IDX_W'(idx); fill_way = way;
    fill_tag = TAG_W'(tag); fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input int idx, input int tag, output int lat, output bit missed,
                        output logic [DATA_W-1:0] d);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_index = IDX_W'(idx); req_tag = TAG_W'(tag);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; missed = 1'b0; d = '0;
    for (int n = 0; n < 8; n++) begin
      if (miss_valid) begin missed = 1'b1; break; end
      if (rsp_valid && !rsp_cancel) begin d = rsp_data; break; end
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lat;
    bit mis;
    logic [DATA_W-1:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_index = '0; req_tag = '0;
    fill_valid = 1'b0; fill_index = '0; fill_way = 1'b0; fill_tag = '0; fill_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet outputs, ready high
    check(rsp_valid === 1'b0, 1, "rsp_valid after reset", 64'(rsp_valid), 0);
    check(miss_valid === 1'b0, 1, "miss_valid after reset", 64'(miss_valid), 0);
    check(req_ready === 1'b1, 1, "req_ready after reset", 64'(req_ready), 1);
    model_on = 1'b1;

    // R1: empty set misses and picks way 0
    lookup(2, 9, lat, mis, d);
    check(mis, 1, "miss on empty set", 64'(mis), 1);

    fill(3, 1'b0, 16'h11, 32'hA0A0_0001);
    fill(3, 1'b1, 16'h22, 32'hB0B0_0002);
    fill(5, 1'b0, 16'h33, 32'hC0C0_0003);
    @(negedge clk);

    // R3 and R2: correct guess, one cycle, filled data
    lookup(3, 16'h11, lat, mis, d);
    check(lat == 1 && !mis, 3, "hit latency", 64'(lat), 1);
    check(d === 32'hA0A0_0001, 2, "filled data", 64'(d), 64'h A0A0_0001);

    // R5, R7: wrong guess, three cycles
    lookup(3, 16'h22, lat, mis, d);
    check(lat == 3 && !mis, 5, "corrected latency", 64'(lat), 3);
    check(d === 32'hB0B0_0002, 5, "corrected data", 64'(d), 64'hB0B0_0002);
    lookup(3, 16'h22, lat, mis, d);
    check(lat == 1, 7, "guess moved to way 1", 64'(lat), 1);

    // R8, R9: both valid, victim is the way not predicted
    lookup(3, 16'h44, lat, mis, d);
    check(mis && last_vic == 1'b0, 8, "victim opposite of guess", 64'(last_vic), 0);
    lookup(5, 16'h55, lat, mis, d);
    check(mis && last_vic == 1'b1, 8, "victim is invalid way 1", 64'(last_vic), 1);
    @(negedge clk);

    // R10: miss followed next cycle by the same set
    req_valid = 1'b1; req_index = 3; req_tag = 16'h66;   // guess 0 -> miss, victim 1
    @(negedge clk);
    req_index = 3; req_tag = 16'h22;                     // must be guessed way 1
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && !rsp_cancel && rsp_data === 32'hB0B0_0002, 10, "bypassed guess",
          64'(rsp_cancel), 0);
    repeat (3) @(negedge clk);

    // R6: request held through a wrong guess is taken only when ready
    lookup(3, 16'h11, lat, mis, d);                      // moves guess to way 0
    req_valid = 1'b1; req_index = 3; req_tag = 16'h22;  // wrong guess now
    @(negedge clk);
    check(req_ready === 1'b0, 6, "blocked after cancel", 64'(req_ready), 0);
    @(negedge clk);
    check(req_ready === 1'b0, 6, "blocked in gap", 64'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && !rsp_cancel, 6, "held request answered once ready", 64'(rsp_cancel), 0);
    repeat (3) @(negedge clk);

    // R11: back-to-back correct guesses on different sets
    fill(1, 1'b0, 16'h71, 32'h0000_0071);
    fill(2, 1'b0, 16'h72, 32'h0000_0072);
    @(negedge clk);
    req_valid = 1'b1;
    for (int r = 0; r < 6; r++) begin
      req_index = (r % 2 == 0) ? 1 : 2;
      req_tag   = (r % 2 == 0) ? 16'h71 : 16'h72;
      @(negedge clk);
      if (r > 0) check(rsp_valid && !rsp_cancel, 11, "streamed hit", 64'(rsp_cancel), 0);
    end
    req_valid = 1'b0;
    repeat (3) @(negedge clk);

    // mixed traffic with refills of each victim
    for (int it = 0; it < 300; it++) begin
      int ix, tg;
      ix = int'($urandom_range(SETS - 1, 0));
      tg = 16'h100 + int'($urandom_range(3, 0));
      lookup(ix, tg, lat, mis, d);
      if (mis) begin
        @(negedge clk);
        fill(ix, last_vic, tg, $urandom);
      end
    end
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule